// File: doc/BRIEF.md
# Interrupt Destination Address Filter

This block decides, for each interrupt message that reaches a local interrupt controller, whether the message is addressed to that controller. A request carries a command word, an 8-bit destination field and a flag that says whether this same unit sent it. The filter reads the shorthand code and the destination mode from the command word. It then compares the destination against the local physical ID or the logical ID, or it applies one of the broadcast and self rules that the shorthand selects.

The logical format is held in a local format register that only the filter uses. Software writes the whole word, but only its top nibble is kept: it selects flat or cluster logical addressing. The block reports a single match flag one clock after a request. An error flag in the same cycle marks a logical-mode request that met an unrecognised format value. How the message is carried and what its delivery mode does are handled elsewhere.

Top module: `irq_dest_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, match_o and error_o are 0. After reset the format register holds all ones, which selects flat logical addressing.
- R2: match_o and error_o reflect the request presented in the previous clock cycle. They are 0 in any cycle after which req_valid_i was low.
- R3: With shorthand 0 and destination mode bit 11 of req_cmd_i at 0 (physical), a match occurs when req_dest_i is 0xFF or equals bits [31:24] of id_reg_i. Otherwise there is no match.
- R4: With shorthand 0, mode bit 11 at 1 (logical) and flat format, a match occurs when req_dest_i AND bits [31:24] of ldr_reg_i is non-zero.
- R5: With shorthand 0, logical mode and cluster format, a match requires two things: the upper nibbles of the destination and the logical ID are equal, and the AND of their lower nibbles is non-zero.
- R6: Shorthand code 1 (bits [19:18] of req_cmd_i) is self: it matches exactly when req_from_self_i is 1. The destination field and mode bit have no effect.
- R7: Shorthand code 2 is all-including-self: it always matches, with error_o at 0.
- R8: Shorthand code 3 is all-excluding-self: it matches exactly when req_from_self_i is 0.
- R9: A write with fmt_wr_en_i stores bits [31:28] of fmt_wr_data_i and forces bits [27:0] to ones. A stored nibble of 0xF selects flat and 0x0 selects cluster, whatever the low bits written. A request in the same cycle as a write is judged against the format held before the write.
- R10: A logical-mode, shorthand-0 request whose stored format nibble is neither 0xF nor 0x0 gives match_o at 0 and error_o at 1 in the output cycle. Physical-mode requests and non-zero shorthands never raise error_o. error_o and match_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_wr_en_i | input | 1 | Write strobe for the format register |
| fmt_wr_data_i | input | 32 | Format register write data |
| id_reg_i | input | 32 | Local ID register; physical ID in [31:24] |
| ldr_reg_i | input | 32 | Logical destination register; logical ID in [31:24] |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_cmd_i | input | 32 | Command word; shorthand [19:18], destination mode [11] |
| req_dest_i | input | 8 | Destination field of the message |
| req_from_self_i | input | 1 | Sender is this same unit |
| match_o | output | 1 | Message targets this controller (one cycle after request) |
| error_o | output | 1 | Unrecognised logical format met (aligned with match_o) |

## Verification
A format-register write and a logical-mode request can land in the same cycle. The rule is that the request sees the format held before the edge that stores the write. The bench provokes this twice. First it writes an invalid nibble while presenting a request that matches under the current cluster format. The expected result is a match with no error, and the next identical request must then give an error with no match. Second it restores flat format in the same cycle as a request under the invalid format. That request must still report the error.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

   localparam int unsigned SH_W  = 2;
   localparam int unsigned SEL_W = 4;

   localparam logic [SEL_W-1:0] SEL_FLAT    = 4'hF;
   localparam logic [SEL_W-1:0] SEL_CLUSTER = 4'h0;

   typedef enum logic [SH_W-1:0] {
      SH_DEST   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef enum logic [1:0] {
      FMT_FLAT    = 2'd0,
      FMT_CLUSTER = 2'd1,
      FMT_BAD     = 2'd2
   } fmt_kind_e;

endpackage

// File: rtl/irq_fmt_reg.sv
module irq_fmt_reg
   import irq_dest_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output fmt_kind_e        kind
);

   localparam int unsigned FILL_W = REG_W - SEL_W;

   logic [REG_W-1:0] fmt_q;
   logic [SEL_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q <= '1;
      end else if (wr_en) begin
         fmt_q <= {wr_data[REG_W-1 -: SEL_W], {FILL_W{1'b1}}};
      end
   end

   assign sel = fmt_q[REG_W-1 -: SEL_W];

   always_comb begin
      if (sel == SEL_FLAT) begin
         kind = FMT_FLAT;
      end else if (sel == SEL_CLUSTER) begin
         kind = FMT_CLUSTER;
      end else begin
         kind = FMT_BAD;
      end
   end

endmodule

// File: rtl/irq_logical_match.sv
module irq_logical_match
   import irq_dest_pkg::*;
#(
   parameter int unsigned ID_W = 8
) (
   input  logic [ID_W-1:0] lid,
   input  logic [ID_W-1:0] dest,
   input  fmt_kind_e       kind,
   output logic            hit,
   output logic            bad
);

   localparam int unsigned HALF = ID_W / 2;

   logic flat_hit;
   logic clus_hit;

   assign flat_hit = |(lid & dest);
   assign clus_hit = (lid[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
                     (|(lid[HALF-1:0] & dest[HALF-1:0]));

   always_comb begin
      hit = 1'b0;
      bad = 1'b0;
      case (kind)
         FMT_FLAT:    hit = flat_hit;
         FMT_CLUSTER: hit = clus_hit;
         default:     bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/irq_physical_match.sv
module irq_physical_match #(
   parameter int unsigned ID_W = 8
) (
   input  logic [ID_W-1:0] pid,
   input  logic [ID_W-1:0] dest,
   output logic            hit
);

   assign hit = (&dest) || (dest == pid);

endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter
   import irq_dest_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned ID_W     = 8,
   parameter int unsigned ID_LSB   = 24,
   parameter int unsigned LDR_LSB  = 24,
   parameter int unsigned SH_LSB   = 18,
   parameter int unsigned MODE_BIT = 11,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fmt_wr_en_i,
   input  logic [REG_W-1:0] fmt_wr_data_i,
   input  logic [REG_W-1:0] id_reg_i,
   input  logic [REG_W-1:0] ldr_reg_i,
   input  logic             req_valid_i,
   input  logic [REG_W-1:0] req_cmd_i,
   input  logic [ID_W-1:0]  req_dest_i,
   input  logic             req_from_self_i,
   output logic             match_o,
   output logic             error_o
);

   if (ID_W < 2 || (ID_W % 2) != 0) begin : g_bad_id_w
      $error("ID_W must be even and at least 2");
   end
   if (REG_W <= SEL_W || ID_LSB + ID_W > REG_W || LDR_LSB + ID_W > REG_W) begin : g_bad_id_pos
      $error("ID fields must lie inside the register width");
   end
   if (SH_LSB + SH_W > REG_W || MODE_BIT >= REG_W) begin : g_bad_cmd_pos
      $error("command fields must lie inside the register width");
   end

   fmt_kind_e       fmt_kind;
   shorthand_e      sh;
   logic            logical;
   logic            phys_hit;
   logic            log_hit;
   logic            log_bad;
   logic            hit_d;
   logic            err_d;

   irq_fmt_reg #(.REG_W(REG_W)) u_fmt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fmt_wr_en_i),
      .wr_data (fmt_wr_data_i),
      .kind    (fmt_kind)
   );

   irq_physical_match #(.ID_W(ID_W)) u_phys (
      .pid  (id_reg_i[ID_LSB +: ID_W]),
      .dest (req_dest_i),
      .hit  (phys_hit)
   );

   irq_logical_match #(.ID_W(ID_W)) u_log (
      .lid  (ldr_reg_i[LDR_LSB +: ID_W]),
      .dest (req_dest_i),
      .kind (fmt_kind),
      .hit  (log_hit),
      .bad  (log_bad)
   );

   assign sh      = shorthand_e'(req_cmd_i[SH_LSB +: SH_W]);
   assign logical = req_cmd_i[MODE_BIT];

   always_comb begin
      hit_d = 1'b0;
      err_d = 1'b0;
      if (req_valid_i) begin
         case (sh)
            SH_DEST: begin
               hit_d = logical ? log_hit : phys_hit;
               err_d = logical & log_bad;
            end
            SH_SELF:   hit_d = req_from_self_i;
            SH_ALL:    hit_d = 1'b1;
            SH_OTHERS: hit_d = !req_from_self_i;
            default: begin
               hit_d = 1'b0;
               err_d = 1'b1;
            end
         endcase
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            match_o <= 1'b0;
            error_o <= 1'b0;
         end else begin
            match_o <= hit_d;
            error_o <= err_d;
         end
      end
   end else begin : g_comb_out
      assign match_o = hit_d;
      assign error_o = err_d;
   end

endmodule

// File: rtl/irq_dest_filter_chk.sv
module irq_dest_filter_chk #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned ID_W     = 8,
   parameter int unsigned ID_LSB   = 24,
   parameter int unsigned SH_LSB   = 18,
   parameter int unsigned MODE_BIT = 11,
   parameter bit          REG_OUT  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] id_reg_i,
   input logic             req_valid_i,
   input logic [REG_W-1:0] req_cmd_i,
   input logic [ID_W-1:0]  req_dest_i,
   input logic             req_from_self_i,
   input logic             match_o,
   input logic             error_o
);

   logic [1:0] sh;
   logic       phys_req;

   assign sh       = req_cmd_i[SH_LSB +: 2];
   assign phys_req = req_valid_i && (sh == 2'd0) && !req_cmd_i[MODE_BIT];

   // R10: the error flag never accompanies a match
   a_r10_err_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> !match_o);

   if (REG_OUT) begin : g_seq
      // R2: no request, quiet outputs next cycle
      a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid_i |=> (!match_o && !error_o));

      // R7: all-including-self always matches
      a_r7_all_match: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid_i && sh == 2'd2) |=> (match_o && !error_o));

      // R6: self shorthand follows the sender flag
      a_r6_self_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid_i && sh == 2'd1) |=> (match_o == $past(req_from_self_i)));

      // R8: all-excluding-self is the inverse of the sender flag
      a_r8_others_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid_i && sh == 2'd3) |=> (match_o == !$past(req_from_self_i)));

      // R3: physical broadcast always matches
      a_r3_phys_bcast: assert property (@(posedge clk) disable iff (!rst_n)
         (phys_req && (&req_dest_i)) |=> (match_o && !error_o));

      // R3: physical own ID matches
      a_r3_phys_own: assert property (@(posedge clk) disable iff (!rst_n)
         (phys_req && req_dest_i == id_reg_i[ID_LSB +: ID_W]) |=> match_o);
   end

endmodule

bind irq_dest_filter irq_dest_filter_chk #(
   .REG_W    (REG_W),
   .ID_W     (ID_W),
   .ID_LSB   (ID_LSB),
   .SH_LSB   (SH_LSB),
   .MODE_BIT (MODE_BIT),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .id_reg_i        (id_reg_i),
   .req_valid_i     (req_valid_i),
   .req_cmd_i       (req_cmd_i),
   .req_dest_i      (req_dest_i),
   .req_from_self_i (req_from_self_i),
   .match_o         (match_o),
   .error_o         (error_o)
);

// File: tb/irq_dest_filter_tb.sv
module irq_dest_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_wr_en_i = 1'b0;
   logic [31:0] fmt_wr_data_i = '0;
   logic [31:0] id_reg_i = 32'h0500_0000;
   logic [31:0] ldr_reg_i = 32'h2100_0000;
   logic        req_valid_i = 1'b0;
   logic [31:0] req_cmd_i = '0;
   logic [7:0]  req_dest_i = '0;
   logic        req_from_self_i = 1'b0;
   logic        match_o;
   logic        error_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_dest_filter u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .fmt_wr_en_i     (fmt_wr_en_i),
      .fmt_wr_data_i   (fmt_wr_data_i),
      .id_reg_i        (id_reg_i),
      .ldr_reg_i       (ldr_reg_i),
      .req_valid_i     (req_valid_i),
      .req_cmd_i       (req_cmd_i),
      .req_dest_i      (req_dest_i),
      .req_from_self_i (req_from_self_i),
      .match_o         (match_o),
      .error_o         (error_o)
   );

   // entry: {sh[1:0], logical, from_self, dest[7:0], lid[7:0], exp_match, exp_err}
   // format is flat, physical ID is 0x05 for the whole table
   localparam int NVEC = 14;
   localparam logic [21:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 1'b0, 8'h05, 8'h21, 1'b1, 1'b0},  // R3 own ID
      {2'd0, 1'b0, 1'b0, 8'h06, 8'h21, 1'b0, 1'b0},  // R3 other ID
      {2'd0, 1'b0, 1'b1, 8'hFF, 8'h21, 1'b1, 1'b0},  // R3 broadcast
      {2'd0, 1'b0, 1'b0, 8'h21, 8'h21, 1'b0, 1'b0},  // R3 logical ID ignored in physical
      {2'd0, 1'b1, 1'b0, 8'h01, 8'h21, 1'b1, 1'b0},  // R4 low bit overlap
      {2'd0, 1'b1, 1'b0, 8'h0C, 8'h21, 1'b0, 1'b0},  // R4 no overlap
      {2'd0, 1'b1, 1'b0, 8'h20, 8'h21, 1'b1, 1'b0},  // R4 high bit overlap
      {2'd0, 1'b1, 1'b0, 8'h05, 8'h80, 1'b0, 1'b0},  // R4 physical ID ignored in logical
      {2'd1, 1'b0, 1'b1, 8'h00, 8'h21, 1'b1, 1'b0},  // R6 self from self
      {2'd1, 1'b0, 1'b0, 8'h05, 8'h21, 1'b0, 1'b0},  // R6 dest ignored
      {2'd2, 1'b1, 1'b0, 8'h00, 8'h21, 1'b1, 1'b0},  // R7 others sender
      {2'd2, 1'b0, 1'b1, 8'h06, 8'h21, 1'b1, 1'b0},  // R7 self sender
      {2'd3, 1'b0, 1'b1, 8'h05, 8'h21, 1'b0, 1'b0},  // R8 self excluded
      {2'd3, 1'b1, 1'b0, 8'h00, 8'h21, 1'b1, 1'b0}   // R8 other sender
   };

   task automatic check(input string tag, input logic exp_m, input logic exp_e);
      compared++;
      if (match_o !== exp_m || error_o !== exp_e) begin
         mismatched++;
         $display("FAIL %s: match=%0b err=%0b expected match=%0b err=%0b",
                  tag, match_o, error_o, exp_m, exp_e);
      end
   endtask

   // called at a falling edge; presents a request, checks it one cycle later
   task automatic send(input logic [1:0] sh, input logic lg, input logic slf,
                       input logic [7:0] dest, input string tag,
                       input logic exp_m, input logic exp_e);
      req_valid_i     = 1'b1;
      req_cmd_i       = (32'(sh) << 18) | (32'(lg) << 11);
      req_dest_i      = dest;
      req_from_self_i = slf;
      @(negedge clk);
      req_valid_i = 1'b0;
      check(tag, exp_m, exp_e);
   endtask

   task automatic fmt_write(input logic [31:0] data);
      fmt_wr_en_i   = 1'b1;
      fmt_wr_data_i = data;
      @(negedge clk);
      fmt_wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL R2 watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R1: outputs quiet under reset, even with a request presented
      req_valid_i = 1'b1;
      req_cmd_i   = 32'(2) << 18;
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 1'b0);
      req_valid_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first cycle after reset", 1'b0, 1'b0);

      // R1: reset format is flat
      send(2'd0, 1'b1, 1'b0, 8'h01, "R1 flat after reset", 1'b1, 1'b0);

      // R2: idle cycle after a match is quiet
      @(negedge clk);
      check("R2 idle after request", 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         ldr_reg_i = {VEC[i][9:2], 24'h0};
         send(VEC[i][21:20], VEC[i][19], VEC[i][18], VEC[i][17:10],
              $sformatf("table entry %0d (R3..R8)", i), VEC[i][1], VEC[i][0]);
      end
      ldr_reg_i = 32'h2100_0000;

      // R9, R5: low bits written are forced to ones; 0x0 nibble is cluster
      fmt_write(32'h0123_4567);
      send(2'd0, 1'b1, 1'b0, 8'h23, "R5 cluster hit", 1'b1, 1'b0);
      send(2'd0, 1'b1, 1'b0, 8'h31, "R5 cluster other cluster", 1'b0, 1'b0);
      send(2'd0, 1'b1, 1'b0, 8'h22, "R5 cluster no member overlap", 1'b0, 1'b0);
      send(2'd0, 1'b1, 1'b0, 8'h01, "R9 flat no longer applies", 1'b0, 1'b0);

      // R9: write and request in same cycle, request sees old (cluster) format
      fmt_wr_en_i   = 1'b1;
      fmt_wr_data_i = 32'h5000_0000;
      send(2'd0, 1'b1, 1'b0, 8'h21, "R9 same-cycle write uses old format", 1'b1, 1'b0);
      fmt_wr_en_i = 1'b0;

      // R10: unknown format gives error, no match
      send(2'd0, 1'b1, 1'b0, 8'h21, "R10 unknown format logical", 1'b0, 1'b1);
      send(2'd0, 1'b0, 1'b0, 8'h05, "R10 unknown format physical no error", 1'b1, 1'b0);
      send(2'd2, 1'b1, 1'b0, 8'h00, "R10 unknown format broadcast no error", 1'b1, 1'b0);
      @(negedge clk);
      check("R10 error lasts one cycle", 1'b0, 1'b0);

      // R9: restore flat in same cycle as a request under the bad format
      fmt_wr_en_i   = 1'b1;
      fmt_wr_data_i = 32'hF000_0000;
      send(2'd0, 1'b1, 1'b0, 8'h01, "R9 restore write same cycle", 1'b0, 1'b1);
      fmt_wr_en_i = 1'b0;
      send(2'd0, 1'b1, 1'b0, 8'h01, "R9 flat restored", 1'b1, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule